// File: doc/BRIEF.md
# Interrupt Controller Error Status Unit

This block collects the error events an interrupt controller detects and turns them into a software-visible status word plus an optional error interrupt. One-cycle event pulses arrive from the send path (checksum failure, nobody accepted the message, illegal vector) and from the receive path (checksum failure, nobody accepted the message including this unit, illegal vector). The receive illegal-vector input also covers vectors found in local vector table entries and in self-interrupts. A register access decoder check runs inside the block. An access that lands in the 4 KB window above the programmable register base, but hits an offset nobody implements, is recorded as an illegal address.

Events collect in a hidden pending word. A write to the status register moves the pending word into the readable status register and clears the pending word. The error entry register holds an 8-bit vector and a mask bit. While the mask bit is clear, every pending flag that goes from 0 to 1 produces a one-cycle interrupt request that carries the vector.

Top module: `err_status_unit`

## Requirements
- R1: After reset the status register reads 0, the error entry reads 0x0001_0000 (masked, vector 0), and `irq_valid` is low.
- R2: Each event pulse sets its own pending flag. The flag positions are: bit 0 send checksum, bit 1 receive checksum, bit 2 send accept, bit 3 receive accept, bit 5 send illegal vector, bit 6 receive illegal vector, bit 7 illegal address. Bit 4 and bits 31:8 of the status read as 0.
- R3: A send vector report (`tx_vec_valid`) with a vector from 0 to 15 sets bit 5. A vector of 16 or more sets nothing.
- R4: A receive-side vector report (`rx_vec_valid`) with a vector from 0 to 15 sets bit 6. A write to the error entry whose bits 7:0 are below 16 also sets bit 6, and the value is still stored.
- R5: An access with `reg_addr[31:12] == reg_base[31:12]` sets bit 7 if its offset `reg_addr[11:0]` is neither the status offset 0x0A0 nor the error entry offset 0x0B4 and `ext_hit` is low. If `ext_hit` is high, the access sets nothing.
- R6: An access outside the window sets no flag, changes no register and reads 0.
- R7: A write to the status offset loads the status register with the pending word as it was before that cycle and clears the pending word. Any event in that same cycle stays pending.
- R8: The error entry stores the vector in bits 7:0 and the mask in bit 16. Its other bits read 0.
- R9: `irq_valid` pulses for one cycle, one clock after a cycle in which some pending flag goes from 0 to 1 while the mask (as held in that cycle) is clear. `irq_vector` is then the stored vector. There is no pulse while the unit is masked, and none for a flag that is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_csum | input | 1 | Send checksum error pulse |
| ev_rx_csum | input | 1 | Receive checksum error pulse |
| ev_tx_noack | input | 1 | Sent message accepted by nobody |
| ev_rx_noack | input | 1 | Received message accepted by nobody |
| tx_vec_valid | input | 1 | Send-side vector report strobe |
| tx_vec | input | 8 | Vector of the message being sent |
| rx_vec_valid | input | 1 | Receive-side, table or self-interrupt vector strobe |
| rx_vec | input | 8 | Vector being checked on the receive side |
| reg_base | input | 32 | Register window base (4 KB aligned) |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | 32 | Access address |
| reg_wdata | input | 32 | Write data |
| ext_hit | input | 1 | Offset is implemented by another register of the controller |
| reg_rdata | output | 32 | Read data (combinational, 0 when not reading here) |
| irq_valid | output | 1 | Error interrupt request pulse |
| irq_vector | output | 8 | Vector carried by the request |

## Verification
Directed sequences check the reset values first. They then raise each event class alone, so a wrong bit position shows up as a misplaced flag. Vectors at 15 and 16 are tried on both paths and in error entry writes, which separates off-by-one limits in the illegal-vector compare. Addresses just below, inside and just above the window, with `ext_hit` in both states, separate a wrong window check from a wrong offset decode. A status write that coincides with a new event, and events that repeat while their flag is already pending, show whether the rising-edge interrupt rule and the copy-and-clear handoff are right. A long run of seeded random events and accesses then compares every read and every interrupt cycle with a bench model.

// File: rtl/err_status_unit.sv
module err_status_unit #(
  parameter int         AW       = 32,
  parameter int         VW       = 8,
  parameter int         MIN_VEC  = 16,
  parameter logic [11:0] OFS_STAT = 12'h0A0,
  parameter logic [11:0] OFS_EVEC = 12'h0B4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_tx_csum,
  input  logic          ev_rx_csum,
  input  logic          ev_tx_noack,
  input  logic          ev_rx_noack,
  input  logic          tx_vec_valid,
  input  logic [VW-1:0] tx_vec,
  input  logic          rx_vec_valid,
  input  logic [VW-1:0] rx_vec,
  input  logic [AW-1:0] reg_base,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic          ext_hit,
  output logic [31:0]   reg_rdata,
  output logic          irq_valid,
  output logic [VW-1:0] irq_vector
);

  logic [7:0]    pend_q, stat_q;
  logic [VW-1:0] vec_q;
  logic          mask_q;

  logic [11:0] ofs;
  logic        win, hit_stat, hit_evec, bad_addr;
  logic        stat_wr, evec_wr;
  logic        tx_bad, rx_bad;
  logic [7:0]  ev, base, rise;

  assign ofs      = reg_addr[11:0];
  assign win      = reg_en && (reg_addr[AW-1:12] == reg_base[AW-1:12]);
  assign hit_stat = win && (ofs == OFS_STAT);
  assign hit_evec = win && (ofs == OFS_EVEC);
  assign bad_addr = win && !hit_stat && !hit_evec && !ext_hit;
  assign stat_wr  = hit_stat && reg_we;
  assign evec_wr  = hit_evec && reg_we;

  assign tx_bad = tx_vec_valid && (int'(tx_vec) < MIN_VEC);
  assign rx_bad = (rx_vec_valid && (int'(rx_vec) < MIN_VEC)) ||
                  (evec_wr && (int'(reg_wdata[VW-1:0]) < MIN_VEC));

  assign ev   = {bad_addr, rx_bad, tx_bad, 1'b0,
                 ev_rx_noack, ev_tx_noack, ev_rx_csum, ev_tx_csum};
  assign base = stat_wr ? 8'h00 : pend_q;
  assign rise = ev & ~base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      stat_q     <= '0;
      vec_q      <= '0;
      mask_q     <= 1'b1;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      pend_q     <= base | ev;
      if (stat_wr) stat_q <= pend_q;
      if (evec_wr) begin
        vec_q  <= reg_wdata[VW-1:0];
        mask_q <= reg_wdata[16];
      end
      irq_valid  <= (|rise) && !mask_q;
      irq_vector <= vec_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_we) begin
      if (hit_stat) reg_rdata[7:0] = stat_q;
      else if (hit_evec) begin
        reg_rdata[VW-1:0] = vec_q;
        reg_rdata[16]     = mask_q;
      end
    end
  end

endmodule

// File: rtl/err_status_chk.sv
module err_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_valid,
  input logic [7:0]  irq_vector,
  input logic [7:0]  pend_q,
  input logic [7:0]  vec_q,
  input logic        mask_q,
  input logic        win,
  input logic        reg_en,
  input logic        tx_vec_valid,
  input logic [7:0]  tx_vec,
  input logic        hit_stat,
  input logic        reg_we,
  input logic [31:0] reg_rdata
);
  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask_q)); // R9
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector == $past(vec_q)); // R9
  AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> pend_q != 8'h00); // R9
  AST_TX_ILLVEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vec_valid && tx_vec < 8'd16) |=> pend_q[5]); // R3
  AST_OUTWIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !win) |=> pend_q[7] == $past(pend_q[7])); // R6
  AST_STAT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stat && !reg_we) |-> (reg_rdata[31:8] == 24'h0 && !reg_rdata[4])); // R2
  AST_FLAG4_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[4]); // R2
endmodule

bind err_status_unit err_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vector(irq_vector),
  .pend_q(pend_q), .vec_q(vec_q), .mask_q(mask_q), .win(win), .reg_en(reg_en),
  .tx_vec_valid(tx_vec_valid), .tx_vec(tx_vec), .hit_stat(hit_stat),
  .reg_we(reg_we), .reg_rdata(reg_rdata)
);

// File: tb/err_status_unit_tb.sv
module err_status_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hFEE0_0000;
  localparam logic [11:0] OS = 12'h0A0;
  localparam logic [11:0] OE = 12'h0B4;

  logic clk = 0, rst_n = 0;
  logic ev_tx_csum, ev_rx_csum, ev_tx_noack, ev_rx_noack;
  logic tx_vec_valid, rx_vec_valid;
  logic [7:0] tx_vec, rx_vec;
  logic [31:0] reg_base, reg_addr, reg_wdata, reg_rdata;
  logic reg_en, reg_we, ext_hit, irq_valid;
  logic [7:0] irq_vector;

  int checks = 0, fails = 0;
  logic [7:0] m_pend, m_stat, m_vec;
  logic m_mask, e_irq;
  logic [7:0] e_irqv;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_status_unit u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic in_win(input logic [31:0] a);
    return a[31:12] == reg_base[31:12];
  endfunction

  function automatic logic [31:0] exp_rd();
    if (!reg_en || reg_we || !in_win(reg_addr)) return 32'h0;
    if (reg_addr[11:0] == OS) return {24'h0, m_stat};
    if (reg_addr[11:0] == OE) return {15'h0, m_mask, 8'h0, m_vec};
    return 32'h0;
  endfunction

  function automatic logic [7:0] exp_ev();
    logic w = reg_en && in_win(reg_addr);
    logic bad = w && reg_addr[11:0] != OS && reg_addr[11:0] != OE && !ext_hit;
    logic rxb = (rx_vec_valid && rx_vec < 16) ||
                (w && reg_we && reg_addr[11:0] == OE && reg_wdata[7:0] < 16);
    return {bad, rxb, tx_vec_valid && tx_vec < 16, 1'b0,
            ev_rx_noack, ev_tx_noack, ev_rx_csum, ev_tx_csum};
  endfunction

  task automatic idle_in();
    {ev_tx_csum, ev_rx_csum, ev_tx_noack, ev_rx_noack} = '0;
    tx_vec_valid = 0; rx_vec_valid = 0; tx_vec = 8'hFF; rx_vec = 8'hFF;
    reg_en = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0; ext_hit = 0;
  endtask

  // inputs set by caller while clk low; completes one cycle
  task automatic step(input string req);
    logic [7:0] ev, b;
    logic sw;
    #1;
    if (reg_en && !reg_we) chk({req, " read"}, reg_rdata, exp_rd());
    ev = exp_ev();
    sw = reg_en && reg_we && in_win(reg_addr) && reg_addr[11:0] == OS;
    b  = sw ? 8'h0 : m_pend;
    e_irq  = (|(ev & ~b)) && !m_mask;
    e_irqv = m_vec;
    @(posedge clk);
    if (sw) m_stat = m_pend;
    if (reg_en && reg_we && in_win(reg_addr) && reg_addr[11:0] == OE) begin
      m_vec = reg_wdata[7:0]; m_mask = reg_wdata[16];
    end
    m_pend = b | ev;
    #1;
    chk({req, " irq_valid"}, {31'h0, irq_valid}, {31'h0, e_irq});
    if (e_irq) chk({req, " irq_vector"}, {24'h0, irq_vector}, {24'h0, e_irqv});
    @(negedge clk);
    idle_in();
  endtask

  task automatic acc(input string req, input logic we, input logic [11:0] o, input logic [31:0] d);
    reg_en = 1; reg_we = we; reg_addr = {reg_base[31:12], o}; reg_wdata = d;
    step(req);
  endtask

  task automatic latch_read(input string req, input logic [7:0] exp);
    acc(req, 1, OS, 0);
    reg_en = 1; reg_we = 0; reg_addr = {reg_base[31:12], OS};
    #1; chk({req, " status"}, reg_rdata, {24'h0, exp});
    step(req);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    reg_base = BASE;
    idle_in();
    m_pend = 0; m_stat = 0; m_vec = 0; m_mask = 1; e_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'h0, irq_valid}, 32'h0);
    reg_en = 1; reg_addr = {BASE[31:12], OS}; #1 chk("R1 status", reg_rdata, 32'h0);
    reg_addr = {BASE[31:12], OE}; #1 chk("R1 entry", reg_rdata, 32'h0001_0000);
    step("R1");
    // R2 each event class, masked
    ev_tx_csum = 1; step("R2"); latch_read("R2 txcsum", 8'h01);
    ev_rx_csum = 1; step("R2"); latch_read("R2 rxcsum", 8'h02);
    ev_tx_noack = 1; step("R2"); latch_read("R2 txnoack", 8'h04);
    ev_rx_noack = 1; step("R2"); latch_read("R2 rxnoack", 8'h08);
    // R3 boundaries
    tx_vec_valid = 1; tx_vec = 8'd16; step("R3"); latch_read("R3 vec16", 8'h00);
    tx_vec_valid = 1; tx_vec = 8'd15; step("R3"); latch_read("R3 vec15", 8'h20);
    // R4 receive path and entry write
    rx_vec_valid = 1; rx_vec = 8'd16; step("R4"); latch_read("R4 vec16", 8'h00);
    rx_vec_valid = 1; rx_vec = 8'd0;  step("R4"); latch_read("R4 vec0", 8'h40);
    acc("R4 entry15", 1, OE, 32'h0001_000F); latch_read("R4 entry15", 8'h40);
    acc("R8 entry read", 0, OE, 0);
    // R8 reserved bits dropped, unmask
    acc("R8 write", 1, OE, 32'hFFFE_FF42);
    acc("R8 read", 0, OE, 0);
    // R5 address window
    acc("R5 bad", 0, 12'h010, 0); latch_read("R5 bad", 8'h80);
    ext_hit = 1; acc("R5 ext", 0, 12'h010, 0); latch_read("R5 ext", 8'h00);
    acc("R5 top", 1, 12'hFFF, 32'h1234); latch_read("R5 top", 8'h80);
    // R6 outside window
    reg_en = 1; reg_we = 1; reg_addr = BASE - 4; reg_wdata = 32'h0000_0005; step("R6 below");
    reg_en = 1; reg_we = 1; reg_addr = BASE + 32'h1000 + OE; reg_wdata = 32'h0001_0003; step("R6 above");
    reg_en = 1; reg_we = 0; reg_addr = BASE + 32'h1000 + OS; #1 chk("R6 read", reg_rdata, 0); step("R6");
    acc("R6 entry kept", 0, OE, 0);
    latch_read("R6 no flag", 8'h00);
    // R7 concurrent event with status write; R9 no repeat irq
    ev_tx_csum = 1; step("R9 rise");
    ev_tx_csum = 1; step("R9 already pending");
    ev_rx_csum = 1; acc("R7 write+event", 1, OS, 0);
    latch_read("R7 kept", 8'h02);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      ev_tx_csum  = ($urandom_range(0, 19) == 0);
      ev_rx_csum  = ($urandom_range(0, 19) == 0);
      ev_tx_noack = ($urandom_range(0, 19) == 0);
      ev_rx_noack = ($urandom_range(0, 19) == 0);
      tx_vec_valid = ($urandom_range(0, 9) == 0); tx_vec = 8'($urandom_range(0, 40));
      rx_vec_valid = ($urandom_range(0, 9) == 0); rx_vec = 8'($urandom_range(0, 40));
      if (r < 40) begin
        reg_en = 1; reg_we = $urandom_range(0, 1);
        ext_hit = $urandom_range(0, 1);
        case ($urandom_range(0, 4))
          0: reg_addr = {BASE[31:12], OS};
          1: reg_addr = {BASE[31:12], OE};
          2: reg_addr = {BASE[31:12], 12'($urandom)};
          3: reg_addr = BASE + 32'h1000 + 32'($urandom_range(0, 4095));
          default: reg_addr = BASE - 32'($urandom_range(1, 4096));
        endcase
        reg_wdata = $urandom;
        if (reg_wdata[3]) reg_wdata[16] = 0;
      end
      step("R9 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule